// File: doc/BRIEF.md
# Soft-Ramping Stereo Volume Controller

This block holds the present attenuation of a two-channel audio output and moves it toward a programmed goal. The attenuation is an unsigned count of 1/8 dB units. Zero means 0 dB. The all-ones value means full mute. Each channel has a volume register in 1/2 dB units, which the block scales by four, and a mute control that forces the channel's goal to full mute.

With soft ramping enabled, the level moves exactly one 1/8 dB unit toward its goal on each audio frame strobe. That strobe is one clock wide, once per left/right period, which gives 1 dB per eight frames. Mute and unmute are ramped in the same way. With soft ramping disabled, the level takes its goal on the next clock edge. A gang control makes register A set the goal of both channels, and register B is then ignored.

A per-channel busy flag tells the downstream gain stage that a ramp is still in progress.

Top module: `volramp_stereo`

## Requirements
- R1: While `rst_n` is low, both levels are forced to full mute (all ones, 1023 with the default width) and both busy flags are 0.
- R2: With `ramp_en` low, a channel's level equals its goal on the clock edge after the goal is applied.
- R3: With `ramp_en` high, a level changes only on an edge where `frame_stb` is high, and then by exactly one unit toward its goal.
- R4: A level never passes its goal. Once it equals the goal, further strobes leave it unchanged.
- R5: With `gang_en` low, the goal of channel A is 4 × `vol_a` and the goal of channel B is 4 × `vol_b`.
- R6: With `gang_en` high, the goal of both channels is derived from `vol_a`, and `vol_b` has no effect on either output.
- R7: A high mute input sets that channel's goal to full mute, and releasing it restores the register goal. Both transitions ramp when `ramp_en` is high and are immediate when it is low.
- R8: If a goal changes during a ramp, the level continues from its present value toward the new goal, with no restart.
- R9: Outside reset, `busy_x` is high exactly when `level_x` differs from that channel's present goal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vol_a | input | VOL_W | Channel A volume register, 1/2 dB units |
| vol_b | input | VOL_W | Channel B volume register, 1/2 dB units |
| mute_a | input | 1 | Mute request, channel A |
| mute_b | input | 1 | Mute request, channel B |
| ramp_en | input | 1 | Soft ramp enable |
| gang_en | input | 1 | Register A drives both channels |
| frame_stb | input | 1 | One-cycle strobe per audio frame |
| level_a | output | VOL_W+2 | Present attenuation, channel A, 1/8 dB units |
| level_b | output | VOL_W+2 | Present attenuation, channel B, 1/8 dB units |
| busy_a | output | 1 | Channel A level differs from its goal |
| busy_b | output | 1 | Channel B level differs from its goal |

## Verification
The assertions check the following on every cycle:
- the level never moves without a strobe;
- no step is larger than one unit;
- there is no movement once a channel is idle;
- the jump to the goal is immediate with ramping off;
- busy is low during reset.

Only the bench scenarios can show the end-to-end behaviour:
- the exact number of strobes that a ramp in each direction takes;
- that a ramp continues from its present value when the goal changes mid-ramp;
- that switching gang mode mid-ramp retargets channel B;
- that register B is ignored while ganged.

// File: rtl/volramp_stereo.sv
module volramp_stereo #(
  parameter int VOL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VOL_W-1:0] vol_a,
  input  logic [VOL_W-1:0] vol_b,
  input  logic             mute_a,
  input  logic             mute_b,
  input  logic             ramp_en,
  input  logic             gang_en,
  input  logic             frame_stb,
  output logic [VOL_W+1:0] level_a,
  output logic [VOL_W+1:0] level_b,
  output logic             busy_a,
  output logic             busy_b
);
  localparam int LVL_W = VOL_W + 2;
  localparam logic [LVL_W-1:0] MUTE_LVL = '1;

  logic [LVL_W-1:0] goal_a, goal_b;
  logic [VOL_W-1:0] src_b;

  assign src_b  = gang_en ? vol_a : vol_b;
  assign goal_a = mute_a ? MUTE_LVL : {vol_a, 2'b00};
  assign goal_b = mute_b ? MUTE_LVL : {src_b, 2'b00};

  function automatic logic [LVL_W-1:0] advance(
    input logic [LVL_W-1:0] cur,
    input logic [LVL_W-1:0] goal
  );
    if (!ramp_en)       return goal;
    else if (!frame_stb) return cur;
    else if (cur < goal) return cur + 1'b1;
    else if (cur > goal) return cur - 1'b1;
    else                 return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_a <= MUTE_LVL;
      level_b <= MUTE_LVL;
    end else begin
      level_a <= advance(level_a, goal_a);
      level_b <= advance(level_b, goal_b);
    end
  end

  assign busy_a = rst_n && (level_a != goal_a);
  assign busy_b = rst_n && (level_b != goal_b);
endmodule

module volramp_stereo_chk #(
  parameter int VOL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VOL_W-1:0] vol_a,
  input logic [VOL_W-1:0] vol_b,
  input logic             mute_a,
  input logic             mute_b,
  input logic             ramp_en,
  input logic             gang_en,
  input logic             frame_stb,
  input logic [VOL_W+1:0] level_a,
  input logic [VOL_W+1:0] level_b,
  input logic             busy_a,
  input logic             busy_b
);
  localparam int LVL_W = VOL_W + 2;
  logic [LVL_W-1:0] ref_a, ref_b;
  assign ref_a = mute_a ? '1 : LVL_W'(vol_a) << 2;
  assign ref_b = mute_b ? '1 : LVL_W'(gang_en ? vol_a : vol_b) << 2;

  // R1
  always @(negedge clk) if (!rst_n) reset_idle_chk: assert (!busy_a && !busy_b);

  // R3
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !frame_stb) |=> $stable(level_a));
  // R3
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !frame_stb) |=> $stable(level_b));
  // R3
  unit_step_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && frame_stb) |=> (level_a == $past(level_a) ||
      level_a == $past(level_a) + 1'b1 || level_a == $past(level_a) - 1'b1));
  // R4
  idle_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !busy_a) |=> $stable(level_a));
  // R4
  idle_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !busy_b) |=> $stable(level_b));
  // R2
  jump_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_en |=> level_a == $past(ref_a));
  // R2
  jump_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_en |=> level_b == $past(ref_b));
endmodule

bind volramp_stereo volramp_stereo_chk #(.VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vol_a(vol_a), .vol_b(vol_b),
  .mute_a(mute_a), .mute_b(mute_b), .ramp_en(ramp_en), .gang_en(gang_en),
  .frame_stb(frame_stb), .level_a(level_a), .level_b(level_b),
  .busy_a(busy_a), .busy_b(busy_b));

// File: tb/volramp_stereo_tb.sv
module volramp_stereo_tb;
  localparam int VOL_W = 8;
  localparam logic [9:0] MUTE = 10'd1023;

  logic clk = 0, rst_n = 0;
  logic [7:0] vol_a = 0, vol_b = 0;
  logic mute_a = 0, mute_b = 0, ramp_en = 0, gang_en = 0, frame_stb = 0;
  logic [9:0] level_a, level_b;
  logic busy_a, busy_b;

  logic [7:0] n_va = 0, n_vb = 0;
  logic n_ma = 0, n_mb = 0, n_ramp = 0, n_gang = 0, n_rst = 0;

  typedef struct { string tag; logic [9:0] la, lb; logic ba, bb; } exp_t;
  exp_t q[$];
  logic [9:0] m_a = MUTE, m_b = MUTE;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  volramp_stereo #(.VOL_W(VOL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .vol_a(vol_a), .vol_b(vol_b),
    .mute_a(mute_a), .mute_b(mute_b), .ramp_en(ramp_en), .gang_en(gang_en),
    .frame_stb(frame_stb), .level_a(level_a), .level_b(level_b),
    .busy_a(busy_a), .busy_b(busy_b));

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] goal_of(input bit chan_b);
    logic [7:0] v;
    v = (chan_b && !gang_en) ? vol_b : vol_a;
    if (chan_b ? mute_b : mute_a) return MUTE;
    return {v, 2'b00};
  endfunction

  function automatic logic [9:0] model_step(input logic [9:0] cur, input logic [9:0] g, input logic stb);
    if (!rst_n) return MUTE;
    if (!ramp_en) return g;
    if (!stb || cur == g) return cur;
    return (cur < g) ? cur + 10'd1 : cur - 10'd1;
  endfunction

  task automatic tick(input string tag, input logic stb);
    exp_t e;
    @(negedge clk);
    rst_n = n_rst; vol_a = n_va; vol_b = n_vb; mute_a = n_ma; mute_b = n_mb;
    ramp_en = n_ramp; gang_en = n_gang; frame_stb = stb;
    @(posedge clk); #1;
    m_a = model_step(m_a, goal_of(0), stb);
    m_b = model_step(m_b, goal_of(1), stb);
    e.tag = tag; e.la = m_a; e.lb = m_b;
    e.ba = rst_n && (m_a != goal_of(0));
    e.bb = rst_n && (m_b != goal_of(1));
    q.push_back(e);
  endtask

  task automatic frames(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      tick(tag, 1'b0);
      tick(tag, 1'b1);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk({e.tag, " level_a"}, level_a, e.la);
        chk({e.tag, " level_b"}, level_b, e.lb);
        chk({e.tag, " busy_a"}, busy_a, e.ba);
        chk({e.tag, " busy_b"}, busy_b, e.bb);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : driver
    // R1 reset state
    n_va = 8'd10; n_vb = 8'd20;
    tick("R1", 1'b1); tick("R1", 1'b1);
    chk("R1 level_a", level_a, 1023); chk("R1 busy_b", busy_b, 0);
    n_rst = 1;
    // R2 R5 immediate independent
    tick("R2", 1'b0);
    chk("R2 level_a", level_a, 40); chk("R5 level_b", level_b, 80);
    // R3 ramp up: 40 -> 48 needs exactly 8 strobes
    n_ramp = 1; n_va = 8'd12;
    tick("R3", 1'b0); tick("R3", 1'b0);
    chk("R3 no-strobe hold", level_a, 40);
    frames("R3", 7);
    chk("R3 after 7 strobes", level_a, 47); chk("R9 busy mid", busy_a, 1);
    frames("R3", 1);
    chk("R3 after 8 strobes", level_a, 48); chk("R9 busy done", busy_a, 0);
    frames("R4", 3);
    chk("R4 no overshoot", level_a, 48);
    // R3 ramp down on B: 80 -> 60
    n_vb = 8'd15;
    frames("R3", 20);
    chk("R3 down 20 strobes", level_b, 60); chk("R9 busy_b done", busy_b, 0);
    // R8 retarget mid-ramp
    n_va = 8'd20;
    frames("R8", 10);
    chk("R8 mid", level_a, 58);
    n_va = 8'd14;
    frames("R8", 2);
    chk("R8 reversed", level_a, 56); chk("R8 idle", busy_a, 0);
    // R6 gang switch mid-ramp on B
    n_vb = 8'd30;
    frames("R6", 5);
    chk("R6 b ramping", level_b, 65);
    n_gang = 1;
    frames("R6", 9);
    chk("R6 b to a goal", level_b, 56); chk("R6 busy_b", busy_b, 0);
    n_vb = 8'd100;
    frames("R6", 4);
    chk("R6 vol_b ignored", level_b, 56); chk("R6 busy_b ignored", busy_b, 0);
    n_ramp = 0; n_vb = 8'd3;
    tick("R6", 1'b0);
    chk("R6 ignored ramp off", level_b, 56);
    // R7 mute ramps
    n_ramp = 1; n_gang = 0; n_vb = 8'd14; n_ma = 1;
    frames("R7", 967);
    chk("R7 muted", level_a, 1023); chk("R7 busy", busy_a, 0);
    n_ma = 0;
    frames("R7", 100);
    chk("R7 unmute ramp", level_a, 923);
    n_ramp = 0;
    tick("R7", 1'b0);
    chk("R7 unmute immediate", level_a, 56);
    n_mb = 1;
    tick("R7", 1'b0);
    chk("R7 mute immediate", level_b, 1023);
    repeat (3) @(posedge clk);
    #7;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule